// File: doc/BRIEF.md
# Word/Byte Serial Frame Controller

This block is the framing engine of a codec-style synchronous serial port. It divides the master clock by four to make the shift clock. It runs two independent lanes. The inbound lane frames data that an external processor shifts into the block on `sdi` and presents the assembled 16-bit word on `in_word`. The outbound lane frames a 16-bit word taken from `out_word` and shifts it out on `sdo`. Each lane has its own active-low frame sync and its own active-low end-of-data strobe, which a processor can use as an interrupt.

A lane starts a transfer when it receives a one-cycle start request. In word mode (`byte_mode` = 0) a transfer is one 16-bit frame. After that frame the end-of-data line gives a pulse one shift clock long. In byte mode (`byte_mode` = 1) a transfer is two 8-bit frames, and each frame needs its own start request. The end-of-data line then acts as a level marker. It goes low when the first byte is finished and stays low until the second byte is finished, so the processor can tell the first byte from the second. Data moves most significant bit first. Outbound data and frame syncs change when the shift clock rises, and inbound data is sampled when it falls.

Top module: `serial_frame_ctrl`

## Requirements
- R1: `sclk` runs at one quarter of the `clk` rate, high for two `clk` cycles and then low for two, repeating.
- R2: While `rst_n` is low, `sclk`, both frame syncs and both end-of-data lines are held high. Reset also discards any start request that has not yet been served.
- R3: In word mode, an `out_start` pulse produces one frame in which `fs_out_n` is low for exactly 16 shift clock periods. During the frame, `sdo` carries `out_word` MSB first, and `sdo` and the frame syncs change only on rising `sclk` edges.
- R4: The MSB of `out_word` is on `sdo` before `fs_out_n` falls, and `sdo` does not change on the edge where `fs_out_n` falls.
- R5: While `fs_in_n` is low, `sdi` is sampled on each falling `sclk` edge, MSB first. At the end of the transfer, `in_word` is updated with the assembled 16 bits.
- R6: In word mode, each lane's end-of-data line falls on the same clock edge as its frame sync rises. It stays low for exactly one shift clock period (4 `clk` cycles).
- R7: In byte mode, a transfer is two frames, each with its frame sync low for exactly 8 shift clock periods. The second frame begins only after a second start request.
- R8: In byte mode, the end-of-data line falls when the first frame's sync rises and stays low through the gap and the second frame. It rises on the same edge as the second frame's sync. With the second request given right after the first frame, it is low for 36 `clk` cycles.
- R9: `byte_mode` is captured when a transfer begins. A change while a transfer is in progress does not alter that transfer's frame lengths or end-of-data behaviour.
- R10: The inbound and outbound lanes run independently and can transfer at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 0 = one 16-bit frame per transfer, 1 = two 8-bit frames |
| out_start | input | 1 | One-cycle request for an outbound frame |
| in_start | input | 1 | One-cycle request for an inbound frame |
| out_word | input | 16 | Word to shift out, captured when the outbound transfer begins |
| sdi | input | 1 | Inbound serial data |
| sclk | output | 1 | Shift clock, `clk` divided by four |
| fs_out_n | output | 1 | Outbound frame sync, active low |
| fs_in_n | output | 1 | Inbound frame sync, active low |
| eod_out_n | output | 1 | Outbound end-of-data strobe or marker, active low |
| eod_in_n | output | 1 | Inbound end-of-data strobe or marker, active low |
| sdo | output | 1 | Outbound serial data |
| in_word | output | 16 | Last inbound word assembled from `sdi` |

## Verification
The hardest case to reach from the ports is a change of `byte_mode` in the middle of a transfer that has already begun. The block must keep the mode it latched. To reach it, the stimulus toggles `byte_mode` on the very cycle it sees the frame sync fall, and then checks the frame lengths and the end-of-data timing against the mode that was present at the start. The byte-mode gap is reached the same way. The bench gives the second start request on the cycle it sees the first frame end, so the 36-cycle end-of-data window is exact.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PREP  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_GAP   = 3'd3,
    ST_EOD   = 3'd4
  } lane_st_e;

  // Number of bits in one frame: half a word in byte mode, a whole word otherwise.
  function automatic int unsigned seg_len(input logic byte_m, input int unsigned word_w);
    return byte_m ? (word_w / 2) : word_w;
  endfunction

endpackage

// File: rtl/sfc_clkdiv.sv
module sfc_clkdiv #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_t,
  output logic fall_t
);
  localparam logic [PH_W-1:0] PH_LAST = '1;
  localparam logic [PH_W-1:0] PH_FALL = PH_W'((1 << (PH_W - 1)) - 1);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph + PH_W'(1);
  end

  // Phase zero while reset is held, so the shift clock sits high.
  assign sclk   = ~ph[PH_W-1];
  assign rise_t = (ph == PH_LAST);
  assign fall_t = (ph == PH_FALL);

  // R1
  sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);
  // R1
  sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |=> !sclk);

endmodule

// File: rtl/sfc_lane_seq.sv
module sfc_lane_seq
  import sfc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_t,
  input  logic fall_t,
  input  logic start,
  input  logic byte_mode,
  output logic fs_n,
  output logic eod_n,
  output logic load_o,
  output logic shift_o,
  output logic sample_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  lane_st_e         state, nxt;
  logic             pend, consume;
  logic             mode_q, mode_n;
  logic             half_q, half_n;
  logic [CNT_W-1:0] cnt;
  logic             seg_last;

  assign seg_last = (cnt == CNT_W'(seg_len(mode_q, WORD_W)));

  always_comb begin
    nxt     = state;
    mode_n  = mode_q;
    half_n  = half_q;
    consume = 1'b0;
    if (rise_t) begin
      unique case (state)
        ST_IDLE: if (pend) begin
          nxt     = ST_PREP;
          mode_n  = byte_mode;
          half_n  = 1'b0;
          consume = 1'b1;
        end
        ST_PREP: nxt = ST_SHIFT;
        ST_SHIFT: if (seg_last) begin
          if (mode_q && !half_q) begin
            nxt    = ST_GAP;
            half_n = 1'b1;
          end else if (mode_q) begin
            nxt = ST_IDLE;
          end else begin
            nxt = ST_EOD;
          end
        end
        ST_GAP: if (pend) begin
          nxt     = ST_SHIFT;
          consume = 1'b1;
        end
        ST_EOD: nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign load_o   = rise_t && (state == ST_IDLE) && pend;
  assign shift_o  = rise_t && (state == ST_SHIFT);
  assign sample_o = fall_t && (state == ST_SHIFT);
  assign done_o   = rise_t && (state == ST_SHIFT) && seg_last && (!mode_q || half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend   <= 1'b0;
      mode_q <= 1'b0;
      half_q <= 1'b0;
      cnt    <= '0;
      fs_n   <= 1'b1;
      eod_n  <= 1'b1;
    end else begin
      state  <= nxt;
      pend   <= start | (pend & ~consume);
      mode_q <= mode_n;
      half_q <= half_n;
      if (rise_t && (nxt == ST_SHIFT) && (state != ST_SHIFT)) cnt <= '0;
      else if (sample_o)                                    cnt <= cnt + CNT_W'(1);
      fs_n   <= !(nxt == ST_SHIFT);
      eod_n  <= !((nxt == ST_GAP) || (nxt == ST_EOD) || ((nxt == ST_SHIFT) && half_n));
    end
  end

  // R3 R7
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_n) |-> seg_last);
  // R6
  eod_word_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eod_n) && !mode_q) |-> $rose(fs_n));
  // R8
  eod_byte_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $rose(eod_n)) |-> $rose(fs_n));

endmodule

// File: rtl/sfc_out_shift.sv
module sfc_out_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              sdo
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= word;
    else if (shift) sreg <= {sreg[WORD_W-2:0], 1'b0};
  end

  assign sdo = sreg[WORD_W-1];

endmodule

// File: rtl/sfc_in_shift.sv
module sfc_in_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              done,
  input  logic              sdi,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      word <= '0;
    end else begin
      if (sample) sreg <= {sreg[WORD_W-2:0], sdi};
      if (done)   word <= sreg;
    end
  end

endmodule

// File: rtl/serial_frame_ctrl.sv
module serial_frame_ctrl #(
  parameter int WORD_W = 16,
  parameter int PH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              out_start,
  input  logic              in_start,
  input  logic [WORD_W-1:0] out_word,
  input  logic              sdi,
  output logic              sclk,
  output logic              fs_out_n,
  output logic              fs_in_n,
  output logic              eod_out_n,
  output logic              eod_in_n,
  output logic              sdo,
  output logic [WORD_W-1:0] in_word
);
  logic rise_t, fall_t;
  logic out_load, out_shift, out_sample, out_done;
  logic in_load, in_shift, in_sample, in_done;

  sfc_clkdiv #(.PH_W(PH_W)) u_div (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise_t(rise_t), .fall_t(fall_t)
  );

  sfc_lane_seq #(.WORD_W(WORD_W)) u_out_seq (
    .clk(clk), .rst_n(rst_n), .rise_t(rise_t), .fall_t(fall_t),
    .start(out_start), .byte_mode(byte_mode),
    .fs_n(fs_out_n), .eod_n(eod_out_n),
    .load_o(out_load), .shift_o(out_shift), .sample_o(out_sample), .done_o(out_done)
  );

  sfc_lane_seq #(.WORD_W(WORD_W)) u_in_seq (
    .clk(clk), .rst_n(rst_n), .rise_t(rise_t), .fall_t(fall_t),
    .start(in_start), .byte_mode(byte_mode),
    .fs_n(fs_in_n), .eod_n(eod_in_n),
    .load_o(in_load), .shift_o(in_shift), .sample_o(in_sample), .done_o(in_done)
  );

  sfc_out_shift #(.WORD_W(WORD_W)) u_out_sh (
    .clk(clk), .rst_n(rst_n), .load(out_load), .shift(out_shift),
    .word(out_word), .sdo(sdo)
  );

  sfc_in_shift #(.WORD_W(WORD_W)) u_in_sh (
    .clk(clk), .rst_n(rst_n), .sample(in_sample), .done(in_done),
    .sdi(sdi), .word(in_word)
  );

  // R3
  fs_out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_out_n) |-> $rose(sclk));
  // R3
  fs_in_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_in_n) |-> $rose(sclk));
  // R3
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $rose(sclk));
  // R4
  msb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_out_n) |-> $stable(sdo));
  // R5
  out_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sample |=> (!sclk && !fs_out_n));
  // R5
  in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_shift |=> $rose(sclk));
  // R4
  in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |=> ($rose(sclk) && fs_in_n));
  // R3
  out_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> $rose(fs_out_n));

endmodule

// File: tb/serial_frame_ctrl_bench.sv
module serial_frame_ctrl_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         byte_mode = 1'b0;
  logic         out_start = 1'b0;
  logic         in_start = 1'b0;
  logic [W-1:0] out_word = '0;
  logic         sdi = 1'b0;
  logic         sclk, fs_out_n, fs_in_n, eod_out_n, eod_in_n, sdo;
  logic [W-1:0] in_word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_frame_ctrl u_serial_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
    .out_start(out_start), .in_start(in_start), .out_word(out_word), .sdi(sdi),
    .sclk(sclk), .fs_out_n(fs_out_n), .fs_in_n(fs_in_n),
    .eod_out_n(eod_out_n), .eod_in_n(eod_in_n), .sdo(sdo), .in_word(in_word)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reset_idle_check(input string req);
    check(sclk == 1'b1, req, "sclk high in reset", sclk, 1);
    check(fs_out_n && fs_in_n, req, "frame syncs high in reset", {fs_out_n, fs_in_n}, 3);
    check(eod_out_n && eod_in_n, req, "eod lines high in reset", {eod_out_n, eod_in_n}, 3);
  endtask

  // R1: sample eight clocks starting at a shift clock rise.
  task automatic clock_ratio_test();
    logic prev;
    int   pat;
    int   guard;
    pat = 0;
    guard = 0;
    @(negedge clk);
    prev = sclk;
    while (!(sclk && !prev) && guard < 20) begin
      prev = sclk;
      @(negedge clk);
      guard++;
    end
    for (int k = 0; k < 8; k++) begin
      pat = (pat << 1) | int'(sclk);
      @(negedge clk);
    end
    check(pat == 8'hCC, "R1", "sclk pattern over 8 clocks", pat, 8'hCC);
  endtask

  // One transfer on one lane; byte mode issues the second request itself.
  task automatic run_xfer(input bit is_in, input logic [W-1:0] word, input bit byte_m,
                          input bit flip, input string req);
    int       seg = 0;
    int       bits0 = 0;
    int       bits1 = 0;
    int       idx = 0;
    int       eod_low = 0;
    logic [W-1:0] got = '0;
    bit       msb_ok = 1'b0;
    bit       seen_fs = 1'b0;
    bit       edge_ok = 1'b1;
    bit       sdo_ok = 1'b1;
    bit       done = 1'b0;
    bit       clr = 1'b0;
    logic     p_sclk, p_fs, p_eod, p_sdo, c_fs, c_eod;
    @(negedge clk);
    byte_mode = byte_m;
    if (is_in) in_start = 1'b1;
    else begin
      out_word  = word;
      out_start = 1'b1;
    end
    @(negedge clk);
    if (is_in) in_start = 1'b0; else out_start = 1'b0;
    p_sclk = sclk;
    p_fs   = is_in ? fs_in_n : fs_out_n;
    p_eod  = is_in ? eod_in_n : eod_out_n;
    p_sdo  = sdo;
    for (int c = 0; c < 400 && !done; c++) begin
      @(negedge clk);
      if (clr) begin
        if (is_in) in_start = 1'b0; else out_start = 1'b0;
        clr = 1'b0;
      end
      c_fs  = is_in ? fs_in_n : fs_out_n;
      c_eod = is_in ? eod_in_n : eod_out_n;
      if (p_fs && !c_fs) begin
        if (!seen_fs) msb_ok = (p_sdo == word[W-1]);
        seen_fs = 1'b1;
        if (flip) byte_mode = ~byte_m;
      end
      if (!is_in && (sdo != p_sdo) && !(sclk && !p_sclk)) sdo_ok = 1'b0;
      if (is_in && sclk && !p_sclk && !c_fs && idx < W) begin
        sdi = word[W-1-idx];
        idx++;
      end
      if (!sclk && p_sclk && !c_fs) begin
        if (seg == 0) bits0++; else bits1++;
        if (!is_in) got = {got[W-2:0], sdo};
      end
      if (!c_eod) eod_low++;
      if (!p_fs && c_fs) begin
        seg++;
        if (byte_m && seg == 1) begin
          if (!(p_eod && !c_eod)) edge_ok = 1'b0;
          if (is_in) in_start = 1'b1; else out_start = 1'b1;
          clr = 1'b1;
        end else if (byte_m) begin
          if (!(!p_eod && c_eod)) edge_ok = 1'b0;
        end else begin
          if (!(p_eod && !c_eod)) edge_ok = 1'b0;
        end
      end else if (p_eod != c_eod && !(byte_m == 1'b0 && !p_eod)) begin
        edge_ok = 1'b0;
      end
      if (!p_eod && c_eod) done = 1'b1;
      p_sclk = sclk;
      p_fs   = c_fs;
      p_eod  = c_eod;
      p_sdo  = sdo;
    end
    check(done, req, "transfer completed", int'(done), 1);
    if (byte_m) begin
      check(bits0 == 8, req, "first byte frame length", bits0, 8);
      check(bits1 == 8, req, "second byte frame length", bits1, 8);
      check(eod_low == 36, req, "byte eod low cycles", eod_low, 36);
    end else begin
      check(bits0 == 16 && seg == 1, req, "word frame length", bits0, 16);
      check(eod_low == 4, req, "word eod low cycles", eod_low, 4);
    end
    check(edge_ok, req, "eod edges aligned with frame sync", int'(edge_ok), 1);
    if (is_in) begin
      check(in_word == word, req, "inbound word", int'(in_word), int'(word));
    end else begin
      check(got == word, req, "outbound bits MSB first", int'(got), int'(word));
      check(msb_ok, req, "MSB on sdo before frame sync falls", int'(msb_ok), 1);
      check(sdo_ok, req, "sdo changes only on sclk rise", int'(sdo_ok), 1);
    end
    if (flip) byte_mode = byte_m;
  endtask

  // R2: reset during a frame stops it and discards pending work.
  task automatic reset_mid_frame_test();
    int guard = 0;
    bit quiet = 1'b1;
    @(negedge clk);
    byte_mode = 1'b0;
    out_word  = 16'hF00F;
    out_start = 1'b1;
    @(negedge clk);
    out_start = 1'b0;
    while (fs_out_n && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    reset_idle_check("R2");
    repeat (4) @(negedge clk);
    reset_idle_check("R2");
    rst_n = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (!fs_out_n || !eod_out_n) quiet = 1'b0;
    end
    check(quiet, "R2", "no frame after reset released", int'(quiet), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_idle_check("R2");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    clock_ratio_test();
    // R3 R4 R6: outbound word
    run_xfer(1'b0, 16'hA5C3, 1'b0, 1'b0, "R3");
    run_xfer(1'b0, 16'h8001, 1'b0, 1'b0, "R4");
    // R5 R6: inbound word
    run_xfer(1'b1, 16'h3C5A, 1'b0, 1'b0, "R5");
    run_xfer(1'b1, 16'hFFFE, 1'b0, 1'b0, "R6");
    // R7 R8: byte mode both lanes
    run_xfer(1'b0, 16'h81E7, 1'b1, 1'b0, "R7");
    run_xfer(1'b1, 16'h6B29, 1'b1, 1'b0, "R8");
    // R9: mode change mid transfer ignored
    run_xfer(1'b0, 16'h4D2E, 1'b0, 1'b1, "R9");
    run_xfer(1'b1, 16'hC071, 1'b1, 1'b1, "R9");
    // R10: both lanes at once
    fork
      run_xfer(1'b0, 16'h1234, 1'b0, 1'b0, "R10");
      run_xfer(1'b1, 16'hFEDC, 1'b0, 1'b0, "R10");
    join
    reset_mid_frame_test();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule